// File: doc/BRIEF.md
# GPIO Port Pad Controller

This block holds the digital control state of one eight-pin port and turns it into pad controls. Each pin is individually set to analog or digital use. A digital pin either drives both levels (push-pull) or only pulls low (open-drain). Software writes and reads three configuration registers over a small register bus. A fourth address returns the pin levels as seen at the pads.

For every pin the block drives three pad controls: a driver enable, a driven value and a weak pull-up enable. Two global inputs shape all pins. A routing enable keeps every pad undriven with its pull-up on until it is raised. A pull-up disable turns every weak pull-up off.

Pad levels come back through a two-stage synchronizer before they reach the read path. Analog pins always read as zero.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset the mode register reads 0xFF (all pins digital), the output-type register reads 0x00 (all open-drain) and the output latch reads 0xFF. The addresses are mode = 0, output type = 1, output latch = 2, port levels = 3.
- R2: While route_en is 0, pad_oe is 0x00 on every pin and pad_pu equals the inverse of pull_dis on every pin, whatever the register contents.
- R3: With route_en at 1, a pin whose mode bit is 0 (analog) has pad_oe and pad_pu both 0.
- R4: A read of address 3 returns 0 in every bit whose mode bit is 0.
- R5: With route_en at 1, a digital pin whose output-type bit is 1 (push-pull) has pad_oe = 1, pad_out equal to its latch bit, and pad_pu = 0.
- R6: With route_en at 1, a digital open-drain pin with latch bit 0 has pad_oe = 1, pad_out = 0 and pad_pu = 0. With latch bit 1 it has pad_oe = 0 and pad_pu = 1, unless pull_dis is 1.
- R7: While pull_dis is 1, pad_pu is 0x00 regardless of any other input or setting.
- R8: A read of address 3 returns, for each digital pin, the pad_in level sampled two clock edges earlier, independent of the output latch.
- R9: A write with wr_en at 1 to address 0, 1 or 2 loads wdata into that register on the next clock edge. A write to address 3 changes no register. Reads return rdata combinationally from addr.
- R10: pad_out is 0 on every pin whose pad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 mode, 1 output type, 2 latch, 3 port levels |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address |
| route_en | input | 1 | Global enable for digital pad driving |
| pull_dis | input | 1 | Global weak pull-up disable |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_oe | output | 8 | Per-pin pad driver enable |
| pad_out | output | 8 | Per-pin pad drive value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |

## Verification
Assertions check the following on every cycle:
- the undriven state before routing is enabled;
- that analog pins stay quiet;
- that no pin has its pull-up on while driving low;
- the global pull-up override;
- the zero read-back of analog pins;
- the load and ignore behaviour of register writes.

Only the bench scenarios can show that the exact per-pin driver, value and pull-up pattern follows from a mixed mode, type and latch setup. They also show that the pad level arrives at the read port exactly two edges after it changes, and that the read-back follows the pad rather than the latch.

// File: rtl/gpio_pad_pkg.sv
// Package: shared constants and the register address map for the port
// pad controller. Assumes a 2-bit register address.
package gpio_pad_pkg;

    localparam int unsigned PORT_W = 8;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_OTYPE = 2'd1,
        SEL_LATCH = 2'd2,
        SEL_PORT  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_cfg_regs.sv
// Module: configuration registers of the port (mode, output type, latch).
// Writes land on the clock edge after a strobe; address SEL_PORT holds no
// register, so a write there is dropped. Assumes synchronous active-low reset.
module gpio_cfg_regs
    import gpio_pad_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] otype_q,
    output logic [W-1:0] latch_q
);

    // Register update: reset defaults, then decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '1;
            otype_q <= '0;
            latch_q <= '1;
        end else if (wr_en) begin
            case (addr)
                SEL_MODE:  mode_q  <= wdata;
                SEL_OTYPE: otype_q <= wdata;
                SEL_LATCH: latch_q <= wdata;
                default:   ;
            endcase
        end
    end

    // R9: a write to mode is visible after the next edge
    a_r9_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_MODE) |=> (mode_q == $past(wdata)));

    // R9: a write to latch is visible after the next edge
    a_r9_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_LATCH) |=> (latch_q == $past(wdata)));

    // R9: a write to the port address leaves all registers unchanged
    a_r9_port_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_PORT) |=>
            ($stable(mode_q) && $stable(otype_q) && $stable(latch_q)));

endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for asynchronous pad levels.
// Assumes STAGES >= 2. Resets to all ones, the level a pulled-up pad shows.
module gpio_in_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    // Shift chain: stage 0 samples the pad, later stages follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
// Module: combinational pad control for one pin. It derives the driver
// enable, drive value, pull-up and read-back bit from the pin settings and
// the two global controls. Assumes the pad level is already synchronized.
module gpio_pin_cell (
    input  logic route_en,
    input  logic pull_dis,
    input  logic is_digital,
    input  logic push_pull,
    input  logic latch_bit,
    input  logic pad_sync,
    output logic oe,
    output logic drv,
    output logic pu,
    output logic rd_bit
);

    logic pu_raw;

    // Pad control: undriven with pull-up until routed, then by mode and type.
    always_comb begin
        oe     = 1'b0;
        drv    = 1'b0;
        pu_raw = 1'b1;
        if (route_en) begin
            if (!is_digital) begin
                pu_raw = 1'b0;
            end else if (push_pull) begin
                oe     = 1'b1;
                drv    = latch_bit;
                pu_raw = 1'b0;
            end else begin
                oe     = ~latch_bit;
                pu_raw = latch_bit;
            end
        end
    end

    // Global pull-up override.
    assign pu = pu_raw & ~pull_dis;

    // Read-back: the receiver is off for analog pins.
    assign rd_bit = is_digital & pad_sync;

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: top of the port pad controller. It joins the configuration
// registers, the pad synchronizer and one pin cell per pin, and muxes the
// read data. Assumes pad_in is asynchronous and rst_n is synchronous.
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int unsigned W      = PORT_W,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         route_en,
    input  logic         pull_dis,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);

    logic [W-1:0] mode_q;
    logic [W-1:0] otype_q;
    logic [W-1:0] latch_q;
    logic [W-1:0] pad_sync;
    logic [W-1:0] port_rd;

    gpio_cfg_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .mode_q  (mode_q),
        .otype_q (otype_q),
        .latch_q (latch_q)
    );

    gpio_in_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar i = 0; i < int'(W); i++) begin : g_pin
        gpio_pin_cell u_cell (
            .route_en   (route_en),
            .pull_dis   (pull_dis),
            .is_digital (mode_q[i]),
            .push_pull  (otype_q[i]),
            .latch_bit  (latch_q[i]),
            .pad_sync   (pad_sync[i]),
            .oe         (pad_oe[i]),
            .drv        (pad_out[i]),
            .pu         (pad_pu[i]),
            .rd_bit     (port_rd[i])
        );

        // R3: routed analog pin neither drives nor pulls up
        a_r3_analog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (route_en && !mode_q[i]) |-> (!pad_oe[i] && !pad_pu[i]));

        // R6: pull-up is off while the pin drives low
        a_r6_no_pu_when_low: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_oe[i] && !pad_out[i]) |-> !pad_pu[i]);
    end

    // Read mux: combinational from addr.
    always_comb begin
        case (addr)
            SEL_MODE:  rdata = mode_q;
            SEL_OTYPE: rdata = otype_q;
            SEL_LATCH: rdata = latch_q;
            default:   rdata = port_rd;
        endcase
    end

    // R2: nothing is driven before routing is enabled
    a_r2_hold_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !route_en |-> (pad_oe == '0));

    // R7: the global disable clears every pull-up
    a_r7_pull_dis: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dis |-> (pad_pu == '0));

    // R4: analog pins read as zero on the port address
    a_r4_analog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == SEL_PORT) |-> ((rdata & ~mode_q) == '0));

    // R10: the drive value is low on undriven pins
    a_r10_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

endmodule

// File: tb/gpio_pad_ctrl_test.sv
// Directed bench for gpio_pad_ctrl: one task per scenario.
module gpio_pad_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       route_en;
    logic       pull_dis;
    logic [7:0] pad_in;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [7:0] pad_pu;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pad_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .route_en (route_en),
        .pull_dis (pull_dis),
        .pad_in   (pad_in),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .pad_pu   (pad_pu)
    );

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(string tag, logic [1:0] a, logic [7:0] exp);
        addr = a;
        #1;
        check8(tag, rdata, exp);
    endtask

    // Expected pad controls, built from R2, R3, R5, R6, R7 and R10.
    task automatic check_pads(string tag, logic [7:0] md, logic [7:0] ty, logic [7:0] la);
        logic [7:0] e_oe, e_out, e_pu;
        for (int i = 0; i < 8; i++) begin
            e_oe[i] = 1'b0; e_out[i] = 1'b0; e_pu[i] = 1'b1;
            if (route_en) begin
                if (!md[i]) e_pu[i] = 1'b0;
                else if (ty[i]) begin e_oe[i] = 1'b1; e_out[i] = la[i]; e_pu[i] = 1'b0; end
                else begin e_oe[i] = ~la[i]; e_pu[i] = la[i]; end
            end
            if (pull_dis) e_pu[i] = 1'b0;
        end
        #1;
        check8({tag, " oe"}, pad_oe, e_oe);
        check8({tag, " out"}, pad_out, e_out);
        check8({tag, " pu"}, pad_pu, e_pu);
    endtask

    // R1, R2: reset register values and the undriven state
    task automatic t_reset();
        reg_read("R1 mode reset", 2'd0, 8'hFF);
        reg_read("R1 otype reset", 2'd1, 8'h00);
        reg_read("R1 latch reset", 2'd2, 8'hFF);
        check_pads("R2 reset pads", 8'hFF, 8'h00, 8'hFF);
    endtask

    // R2, R7: configuration has no pad effect before routing
    task automatic t_pre_route();
        reg_write(2'd0, 8'h0F);
        reg_write(2'd1, 8'h03);
        reg_write(2'd2, 8'h06);
        check_pads("R2 unrouted pads", 8'h0F, 8'h03, 8'h06);
        @(negedge clk); pull_dis = 1'b1;
        check_pads("R7 unrouted pull_dis", 8'h0F, 8'h03, 8'h06);
        check8("R7 unrouted pu zero", pad_pu, 8'h00);
        @(negedge clk); pull_dis = 1'b0;
    endtask

    // R3, R5, R6, R10: mixed modes after routing
    task automatic t_modes();
        @(negedge clk); route_en = 1'b1;
        check_pads("R5 R6 R3 mixed", 8'h0F, 8'h03, 8'h06);
        check8("R3 R5 R6 oe literal", pad_oe, 8'h0B);
        check8("R5 out literal", pad_out, 8'h02);
        check8("R6 pu literal", pad_pu, 8'h04);
        reg_write(2'd2, 8'hF9);
        check_pads("R6 R5 latch flipped", 8'h0F, 8'h03, 8'hF9);
        @(negedge clk); pull_dis = 1'b1;
        check_pads("R7 routed pull_dis", 8'h0F, 8'h03, 8'hF9);
        @(negedge clk); pull_dis = 1'b0;
        reg_write(2'd0, 8'hF0);
        reg_write(2'd1, 8'h00);
        check_pads("R6 R3 open-drain upper", 8'hF0, 8'h00, 8'hF9);
    endtask

    // R4, R8: pad read-back latency and masking
    task automatic t_readback();
        reg_write(2'd0, 8'h0F);
        reg_write(2'd2, 8'h00);
        @(negedge clk); pad_in = 8'h00;
        repeat (3) @(negedge clk);
        reg_read("R8 R4 settled low", 2'd3, 8'h00);
        pad_in = 8'hFF;
        @(negedge clk);
        reg_read("R8 one edge old value", 2'd3, 8'h00);
        @(negedge clk);
        reg_read("R8 R4 two edges", 2'd3, 8'h0F);
        pad_in = 8'hA5;
        repeat (2) @(negedge clk);
        reg_read("R8 R4 pattern, not latch", 2'd3, 8'h05);
    endtask

    // R9: a write to the port address changes nothing
    task automatic t_port_write();
        reg_write(2'd1, 8'h5A);
        reg_write(2'd3, 8'h33);
        reg_read("R9 mode kept", 2'd0, 8'h0F);
        reg_read("R9 otype kept", 2'd1, 8'h5A);
        reg_read("R9 latch kept", 2'd2, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
        route_en = 1'b0; pull_dis = 1'b0; pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pre_route();
        t_modes();
        t_readback();
        t_port_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule